// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides a fast sample clock by a programmable integer from 1 to 8. It produces a divided clock level and a one-cycle enable that marks the start of each output period. It also reports whether the chosen ratio needs downstream duty-cycle correction. Several of these dividers can be brought into phase by an external sync pulse. The pulse arrives asynchronously, is resynchronized, and on its rising edge returns the divider counter to its starting phase.

Configuration is applied through a write strobe that loads the ratio and two realignment control bits. The realignment can be turned off, can act on every sync pulse, or can act only on the first sync pulse after each write. A sticky status output shows that a realignment has taken place since the last write.

Top module: `sync_clk_div`

## Requirements
- R1: `cfg_ratio_i` holds N-1, where N is the divide ratio (1 to 8). With the ratio applied, `div_en_o` is high for exactly one cycle in every N cycles.
- R2: A valid sync event restarts the output period. Counting the rising clock edge that first samples `sync_raw_i` high as edge 1, `div_en_o` and `div_clk_o` are both high after edge 3, and the next period start comes N cycles later.
- R3: The mode bits are captured on a write. With `cfg_sync_en_i`=0, sync pulses have no effect. With `cfg_sync_en_i`=1 and `cfg_sync_once_i`=0, every sync event realigns. With both bits at 1, only the first sync event after the write realigns.
- R4: In one-shot mode, later sync pulses are ignored, with output phase and status unchanged, until a new write re-arms the block. Reset leaves the block disarmed.
- R5: `sync_raw_i` is edge-detected after synchronization. A pulse held high for many cycles is one event.
- R6: Each period begins with the high phase. For even N, `div_clk_o` is high for N/2 cycles. For odd N, it is high for (N+1)/2 cycles and low for (N-1)/2 cycles.
- R7: `duty_fix_req_o` is 0 when the applied ratio is 1, 2 or 4, and 1 when it is 3, 5, 6, 7 or 8.
- R8: A new ratio takes effect at the next counter wrap or at the next realignment, whichever comes first. No period is cut short, and `duty_fix_req_o` only changes at a period start.
- R9: `sync_seen_o` is set by a realignment and stays set until the next configuration write clears it.
- R10: After reset the ratio is 1, the counter is at zero, one-shot mode is disarmed and realignment is off. `div_clk_o`=1, `div_en_o`=1, `duty_fix_req_o`=0 and `sync_seen_o`=0.
- R11: At ratio 1, `div_clk_o` and `div_en_o` stay high. A sync event changes only `sync_seen_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_raw_i | input | 1 | Asynchronous sync pulse |
| cfg_we_i | input | 1 | Configuration write strobe; also re-arms one-shot mode |
| cfg_ratio_i | input | 3 | Divide ratio minus one |
| cfg_sync_en_i | input | 1 | Enables sync realignment |
| cfg_sync_once_i | input | 1 | Selects realignment on the first sync after a write only |
| div_clk_o | output | 1 | Divided clock level |
| div_en_o | output | 1 | High in the first cycle of each output period |
| duty_fix_req_o | output | 1 | Applied ratio needs duty-cycle correction |
| sync_seen_o | output | 1 | Sticky realignment flag |

## Verification
Every ratio from 1 to 8 is run free with no sync activity. This separates period length and high/low split errors from errors in the sync path. Sync pulses are then sent in each of the three modes at spacings that fall at varying counter phases. This shows whether a pulse is ignored, applied once or applied every time. A sync held high for many cycles separates edge detection from level sensing. A ratio rewrite part way through a long period shows whether the new ratio waits for the wrap. One-shot sequences with several pulses, followed by a rewrite, test arming and disarming and the clearing of the sticky flag.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [1:0] {
    SYNC_OFF   = 2'd0,
    SYNC_EVERY = 2'd1,
    SYNC_ONCE  = 2'd2
  } sync_mode_e;

  // ratios that are not 1, 2 or 4 need downstream duty correction
  function automatic logic needs_duty_fix(input int unsigned n);
    return !(n == 1 || n == 2 || n == 4);
  endfunction

endpackage

// File: rtl/cdiv_sync_edge.sv
module cdiv_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b0;
      else if (g == 0) sh_q[g] <= d_i;
      else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
    end
  end

  // last stage only serves edge detection
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic               cfg_sync_en_i,
  input  logic               cfg_sync_once_i,
  input  logic               sync_rise_i,
  output logic [RATIO_W-1:0] ratio_pend_o,
  output logic               realign_o,
  output logic               once_o,
  output logic               armed_o,
  output logic               seen_o
);

  sync_mode_e         mode_q, mode_d;
  logic [RATIO_W-1:0] ratio_q;
  logic               armed_q, seen_q;

  always_comb begin
    if (!cfg_sync_en_i)      mode_d = SYNC_OFF;
    else if (cfg_sync_once_i) mode_d = SYNC_ONCE;
    else                     mode_d = SYNC_EVERY;
  end

  assign realign_o = sync_rise_i &
                     ((mode_q == SYNC_EVERY) | ((mode_q == SYNC_ONCE) & armed_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      mode_q  <= SYNC_OFF;
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (cfg_we_i) begin
      // a write wins over a coincident realignment for arming and status
      ratio_q <= cfg_ratio_i;
      mode_q  <= mode_d;
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      if (realign_o) seen_q <= 1'b1;
      if (realign_o && mode_q == SYNC_ONCE) armed_q <= 1'b0;
    end
  end

  assign ratio_pend_o = ratio_q;
  assign once_o       = (mode_q == SYNC_ONCE);
  assign armed_o      = armed_q;
  assign seen_o       = seen_q;

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
  import cdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_pend_i,
  input  logic               realign_i,
  output logic               div_clk_o,
  output logic               div_en_o,
  output logic               duty_fix_o
);

  localparam int unsigned HL_W = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt_q, cnt_d, act_q, act_d;
  logic [HL_W-1:0]    high_len;
  logic               load, clk_q, en_q, fix_q;

  // pending ratio is only applied at a period boundary
  assign load  = realign_i | (cnt_q == act_q);
  assign cnt_d = load ? '0 : cnt_q + 1'b1;
  assign act_d = load ? ratio_pend_i : act_q;

  // high phase = ceil(N/2) = (act+2)>>1
  assign high_len = ({1'b0, act_d} + HL_W'(2)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      clk_q <= 1'b1;
      en_q  <= 1'b1;
      fix_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      clk_q <= ({1'b0, cnt_d} < high_len);
      en_q  <= (cnt_d == '0);
      fix_q <= needs_duty_fix(32'(act_d) + 32'd1);
    end
  end

  assign div_clk_o  = clk_q;
  assign div_en_o   = en_q;
  assign duty_fix_o = fix_q;

endmodule

// File: rtl/sync_clk_div.sv
module sync_clk_div
  import cdiv_pkg::*;
#(
  parameter int unsigned RATIO_W     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_raw_i,
  input  logic               cfg_we_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic               cfg_sync_en_i,
  input  logic               cfg_sync_once_i,
  output logic               div_clk_o,
  output logic               div_en_o,
  output logic               duty_fix_req_o,
  output logic               sync_seen_o
);

  logic               sync_rise, realign, sync_once, armed;
  logic [RATIO_W-1:0] ratio_pend;

  cdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_raw_i),
    .rise_o (sync_rise)
  );

  cdiv_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_we_i        (cfg_we_i),
    .cfg_ratio_i     (cfg_ratio_i),
    .cfg_sync_en_i   (cfg_sync_en_i),
    .cfg_sync_once_i (cfg_sync_once_i),
    .sync_rise_i     (sync_rise),
    .ratio_pend_o    (ratio_pend),
    .realign_o       (realign),
    .once_o          (sync_once),
    .armed_o         (armed),
    .seen_o          (sync_seen_o)
  );

  cdiv_core #(.RATIO_W(RATIO_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ratio_pend_i (ratio_pend),
    .realign_i    (realign),
    .div_clk_o    (div_clk_o),
    .div_en_o     (div_en_o),
    .duty_fix_o   (duty_fix_req_o)
  );

endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_we_i,
  input logic div_clk_o,
  input logic div_en_o,
  input logic duty_fix_req_o,
  input logic sync_seen_o,
  input logic realign_i,
  input logic once_i,
  input logic armed_i
);

  // each period opens with its high phase
  p_start_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o |-> div_clk_o);

  // a write always leaves the sticky flag clear
  p_seen_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !sync_seen_o);

  // realignment restarts the period
  p_realign_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_seen_o) |-> div_en_o);

  // duty flag only moves at a period boundary
  p_flag_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_fix_req_o) |-> div_en_o);

  // one-shot mode disarms after use
  p_disarm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (realign_i && once_i && !cfg_we_i) |=> !armed_i);

  // a realignment without a coincident write sets the status
  p_seen_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (realign_i && !cfg_we_i) |=> sync_seen_o);

endmodule

bind sync_clk_div cdiv_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_we_i       (cfg_we_i),
  .div_clk_o      (div_clk_o),
  .div_en_o       (div_en_o),
  .duty_fix_req_o (duty_fix_req_o),
  .sync_seen_o    (sync_seen_o),
  .realign_i      (realign),
  .once_i         (sync_once),
  .armed_i        (armed)
);

// File: tb/sim_sync_clk_div.sv
module sim_sync_clk_div;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_raw = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_ratio = '0;
  logic       cfg_en = 1'b0;
  logic       cfg_once = 1'b0;
  logic       div_clk, div_en, fix_req, seen;

  always #10 clk = ~clk;

  sync_clk_div u0 (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .sync_raw_i      (sync_raw),
    .cfg_we_i        (cfg_we),
    .cfg_ratio_i     (cfg_ratio),
    .cfg_sync_en_i   (cfg_en),
    .cfg_sync_once_i (cfg_once),
    .div_clk_o       (div_clk),
    .div_en_o        (div_en),
    .duty_fix_req_o  (fix_req),
    .sync_seen_o     (seen)
  );

  typedef struct {
    logic  c, e, f, s;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  string tag = "R10";
  int    n_chk = 0, n_bad = 0;

  // reference state, built from the requirements
  int m_cnt, m_act, m_pend, m_mode, m_armed, m_seen;
  logic [2:0] m_sh;

  task automatic check(input string t, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic rise, re, ld;
    exp_t it;
    if (!rst_ni) begin
      m_cnt = 0; m_act = 0; m_pend = 0; m_mode = 0; m_armed = 0; m_seen = 0; m_sh = '0;
      return;
    end
    rise = m_sh[1] & ~m_sh[2];
    re   = rise && (m_mode == 1 || (m_mode == 2 && m_armed != 0));
    ld   = re || (m_cnt == m_act);
    m_cnt = ld ? 0 : m_cnt + 1;
    if (ld) m_act = m_pend;
    if (cfg_we) begin
      m_pend  = int'(cfg_ratio);
      m_mode  = !cfg_en ? 0 : (cfg_once ? 2 : 1);
      m_armed = 1;
      m_seen  = 0;
    end else begin
      if (re) m_seen = 1;
      if (re && m_mode == 2) m_armed = 0;
    end
    m_sh = {m_sh[1:0], sync_raw};
    it.c = (m_cnt < (m_act + 2) / 2);
    it.e = (m_cnt == 0);
    it.f = !(m_act == 0 || m_act == 1 || m_act == 3);
    it.s = (m_seen != 0);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) model_step();

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, div_clk, e.c, "div_clk");
      check(e.tag, div_en,  e.e, "div_en");
      check(e.tag, fix_req, e.f, "duty_fix");
      check(e.tag, seen,    e.s, "sync_seen");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ratio, input logic en, input logic once);
    @(negedge clk);
    cfg_ratio = 3'(ratio - 1);
    cfg_en = en;
    cfg_once = once;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk);
    sync_raw = 1'b1;
    repeat (len) @(negedge clk);
    sync_raw = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    // R10 reset state
    check("R10", div_clk, 1'b1, "div_clk");
    check("R10", div_en,  1'b1, "div_en");
    check("R10", fix_req, 1'b0, "duty_fix");
    check("R10", seen,    1'b0, "sync_seen");
    rst_ni = 1'b1;
    cyc(6);

    // R11 ratio one with sync
    tag = "R11";
    wr(1, 1'b1, 1'b0);
    pulse(2);
    cyc(6);
    check("R11", seen, 1'b1, "sync_seen");

    // R1 / R7 every ratio free running
    tag = "R1";
    for (int r = 1; r <= 8; r++) begin
      wr(r, 1'b0, 1'b0);
      cyc(3 * r + 10);
      check("R7", fix_req, !(r == 1 || r == 2 || r == 4), "duty_fix");
    end

    // R6 direct split for N=5
    tag = "R6";
    wr(5, 1'b0, 1'b0);
    cyc(12);
    for (int i = 0; i < 12; i++) begin
      if (div_en) break;
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      check("R6", div_clk, (i < 3), "div_clk N=5");
      @(negedge clk);
    end

    // R8 ratio change mid-period
    tag = "R8";
    wr(8, 1'b0, 1'b0);
    cyc(20);
    for (int i = 0; i < 12; i++) begin
      if (div_en) break;
      @(negedge clk);
    end
    cyc(2);
    wr(3, 1'b0, 1'b0);
    cyc(20);
    wr(6, 1'b1, 1'b0);
    cyc(2);
    wr(2, 1'b1, 1'b0);
    pulse(1);
    cyc(15);

    // R3 disabled, then every-pulse mode
    tag = "R3";
    wr(6, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      pulse(1);
      cyc(3 + i);
    end
    check("R3", seen, 1'b0, "sync_seen when off");
    wr(6, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      pulse(1 + i);
      cyc(4 + 2 * i);
    end

    // R2 direct realignment timing, N=8
    tag = "R2";
    wr(8, 1'b1, 1'b0);
    cyc(19);
    @(negedge clk);
    sync_raw = 1'b1;
    @(negedge clk);
    sync_raw = 1'b0;
    cyc(2);
    check("R2", div_en,  1'b1, "div_en after sync");
    check("R2", div_clk, 1'b1, "div_clk after sync");
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      check("R2", div_en, 1'b0, "div_en inside period");
    end
    @(negedge clk);
    check("R2", div_en, 1'b1, "div_en next period");

    // R4 one-shot arming
    tag = "R4";
    wr(7, 1'b1, 1'b1);
    pulse(1);
    cyc(5);
    check("R4", seen, 1'b1, "sync_seen first pulse");
    for (int i = 0; i < 3; i++) begin
      pulse(1);
      cyc(2 + 3 * i);
    end
    wr(7, 1'b1, 1'b1);
    check("R9", seen, 1'b0, "sync_seen after write");
    cyc(3);
    pulse(1);
    cyc(9);
    pulse(1);
    cyc(11);

    // R5 long sync level
    tag = "R5";
    wr(7, 1'b1, 1'b0);
    cyc(3);
    pulse(40);
    cyc(10);
    wr(4, 1'b1, 1'b1);
    pulse(30);
    cyc(10);

    // R9 sticky then cleared
    tag = "R9";
    wr(3, 1'b1, 1'b0);
    pulse(1);
    cyc(20);
    check("R9", seen, 1'b1, "sync_seen sticky");
    wr(3, 1'b1, 1'b0);
    check("R9", seen, 1'b0, "sync_seen cleared");
    cyc(8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule